// File: doc/BRIEF.md
# Periodic Interval Timer

A word-addressed timer peripheral that produces a periodic level interrupt. A fixed divide-by-16 prescaler feeds a 20-bit interval counter. The counter runs from zero up to a programmed period value, then returns to zero. Each return to zero adds one to a 12-bit count of finished periods and sets a status flag.

Software programs the period and the enables through a mode register. It learns how far the timer has advanced through two read views that return the same word, the live interval count and the number of finished periods. One view acknowledges: reading it clears the period count and the status flag. The other view can be read freely and changes nothing.

When software clears the enable, the current period still finishes. The counter halts only once its count is back at zero, and software can poll the count to see that it has stopped.

Top module: `pit_timer`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears the mode, the interval count, the period count, the status flag and the prescaler. With no enable written, the interval count stays at zero, and irq is low during and after reset.
- R2: Register offsets are 0x00 mode (read/write), 0x04 status, 0x08 acknowledging value view and 0x0C side-effect-free image view. Mode holds the period value P in bits [19:0], the timer enable in bit 24 and the interrupt enable in bit 25. Its other bits read as zero. Writes to any offset other than 0x00 have no effect, and reads of any other offset return zero. A read is taken when rd_en is high at a rising edge. rdata shows the register contents from before that edge, is valid after it, and holds until the next read.
- R3: While running, the interval count advances once every 16 clock cycles. The first advance happens at the 16th rising edge after the edge that wrote the enable.
- R4: The interval count steps 0, 1, ..., P and then returns to 0, so one period lasts P+1 prescaled ticks. With P=0, every tick ends a period.
- R5: Both views return the interval count in bits [19:0] and the number of periods finished since the last acknowledge in bits [31:20].
- R6: The period count wraps modulo 4096 and advances whether or not the interrupt enable is set.
- R7: A read of 0x08 clears the period count and the status flag, and a read of 0x0C changes nothing. If a period ends on the same edge as an acknowledge, that period is kept, leaving a period count of 1 and the status flag set.
- R8: Status bit 0 sets when a period ends and reads as 0 in every other bit position. irq is high exactly while the status flag and the interrupt enable are both 1.
- R9: After the enable is cleared, counting continues until the interval count returns to zero, and that period is counted. The timer then stops with the count at zero. A later enable restarts the prescaler from zero, giving the R3 timing again.
- R10: Writing the mode register never resets the counters. The period value is sampled while the interval count is zero, so a new value written while the count is nonzero takes effect only after the next return to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| rd_en | input | 1 | Read strobe for the addressed register |
| addr | input | 5 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
A bad prescaler phase shows up within 16 cycles as an interval count that is off by one tick at the exact edges where a tick is expected. A period limit that is wrong, or latched at the wrong time, shows up within one period as a count that passes P or returns to zero early, and the period count and status flag go wrong at the same moment. The bench places its reads on the tick edges themselves: the first advance, the period ends, an acknowledge that lands on a period end, and the edge at which the timer stops after the enable is cleared. It also checks the period count after more than 4096 periods, to expose a missing wrap.

// File: rtl/pit_pkg.sv
package pit_pkg;
   // Register byte offsets; software depends on these
   localparam int unsigned OFS_MODE   = 32'h00;
   localparam int unsigned OFS_STATUS = 32'h04;
   localparam int unsigned OFS_ACKVAL = 32'h08;
   localparam int unsigned OFS_IMAGE  = 32'h0C;

   // Mode register control bit positions
   localparam int unsigned MODE_RUN_BIT = 24;
   localparam int unsigned MODE_IRQ_BIT = 25;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_MODE,
      SEL_STATUS,
      SEL_ACKVAL,
      SEL_IMAGE
   } reg_sel_e;
endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
   parameter int unsigned DIV = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   generate
      if (DIV < 1) begin : g_bad_div
         $error("pit_prescaler: DIV must be at least 1");
      end

      if (DIV == 1) begin : g_bypass
         logic unused_bypass;
         assign unused_bypass = clk ^ rst_n;
         assign tick = run;
      end else begin : g_div
         localparam int unsigned PW = $clog2(DIV);
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         logic [PW-1:0] phase_q;

         assign tick = run && (phase_q == LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               phase_q <= '0;
            end else if (!run || tick) begin
               phase_q <= '0;
            end else begin
               phase_q <= phase_q + 1'b1;
            end
         end

         AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick) else $error("tick on adjacent cycles"); // R3
      end
   endgenerate
endmodule

// File: rtl/pit_interval.sv
module pit_interval #(
   parameter int unsigned CNT_W = 20,
   parameter int unsigned OVF_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             tick,
   input  logic             ack,
   input  logic [CNT_W-1:0] period_in,
   output logic             running,
   output logic [CNT_W-1:0] cnt_q,
   output logic [OVF_W-1:0] ovf_q,
   output logic             status_q
);
   logic [CNT_W-1:0] held_period_q;
   logic [CNT_W-1:0] limit;
   logic             at_zero;
   logic             wrap;

   assign at_zero = (cnt_q == '0);
   // a period is bounded by the value seen while the count sits at zero
   assign limit   = at_zero ? period_in : held_period_q;
   assign wrap    = tick && (cnt_q == limit);
   // keep going after the enable drops until the count is back at zero
   assign running = enable || !at_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_period_q <= '0;
      end else if (at_zero) begin
         held_period_q <= period_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (wrap) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q    <= '0;
         status_q <= 1'b0;
      end else if (ack) begin
         ovf_q    <= wrap ? OVF_W'(1) : '0;
         status_q <= wrap;
      end else if (wrap) begin
         ovf_q    <= ovf_q + 1'b1;
         status_q <= 1'b1;
      end
   end

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0) |-> (cnt_q <= held_period_q)) else $error("count beyond period"); // R10
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !tick) |=> (ovf_q == '0 && !status_q)) else $error("ack did not clear"); // R7
   AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && at_zero) |=> (cnt_q == '0)) else $error("count moved while stopped"); // R9
endmodule

// File: rtl/pit_regs.sv
module pit_regs
   import pit_pkg::*;
#(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 20,
   parameter int unsigned OVF_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [CNT_W-1:0]  cnt,
   input  logic [OVF_W-1:0]  ovf,
   input  logic              status,
   output logic [CNT_W-1:0]  period,
   output logic              run_en,
   output logic              irq_en,
   output logic              ack,
   output logic [DATA_W-1:0] rdata
);
   localparam int unsigned PAD_W = DATA_W - CNT_W - OVF_W;

   reg_sel_e          sel;
   logic [DATA_W-1:0] mode_word;
   logic [DATA_W-1:0] count_word;
   logic [DATA_W-1:0] status_word;
   logic [DATA_W-1:0] rd_mux;
   logic              unused_wdata;

   assign unused_wdata = ^wdata;

   always_comb begin
      unique case (addr)
         ADDR_W'(OFS_MODE):   sel = SEL_MODE;
         ADDR_W'(OFS_STATUS): sel = SEL_STATUS;
         ADDR_W'(OFS_ACKVAL): sel = SEL_ACKVAL;
         ADDR_W'(OFS_IMAGE):  sel = SEL_IMAGE;
         default:             sel = SEL_NONE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period <= '0;
         run_en <= 1'b0;
         irq_en <= 1'b0;
      end else if (wr_en && sel == SEL_MODE) begin
         period <= wdata[CNT_W-1:0];
         run_en <= wdata[MODE_RUN_BIT];
         irq_en <= wdata[MODE_IRQ_BIT];
      end
   end

   always_comb begin
      mode_word               = '0;
      mode_word[CNT_W-1:0]    = period;
      mode_word[MODE_RUN_BIT] = run_en;
      mode_word[MODE_IRQ_BIT] = irq_en;
      status_word             = '0;
      status_word[0]          = status;
   end

   generate
      if (PAD_W == 0) begin : g_count_full
         assign count_word = {ovf, cnt};
      end else begin : g_count_pad
         assign count_word = {{PAD_W{1'b0}}, ovf, cnt};
      end
   endgenerate

   always_comb begin
      unique case (sel)
         SEL_MODE:              rd_mux = mode_word;
         SEL_STATUS:            rd_mux = status_word;
         SEL_ACKVAL, SEL_IMAGE: rd_mux = count_word;
         default:               rd_mux = '0;
      endcase
   end

   assign ack = rd_en && (sel == SEL_ACKVAL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (rd_en) begin
         rdata <= rd_mux;
      end
   end
endmodule

// File: rtl/pit_timer.sv
module pit_timer
   import pit_pkg::*;
#(
   parameter int unsigned ADDR_W   = 5,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned CNT_W    = 20,
   parameter int unsigned OVF_W    = 12,
   parameter int unsigned PRESCALE = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq
);
   generate
      if (CNT_W + OVF_W > DATA_W) begin : g_bad_fields
         $error("pit_timer: count fields exceed the data width");
      end
      if (CNT_W > MODE_RUN_BIT || MODE_IRQ_BIT >= DATA_W) begin : g_bad_mode
         $error("pit_timer: period field overlaps the mode control bits");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         $error("pit_timer: address too narrow for four registers");
      end
   endgenerate

   logic [CNT_W-1:0] period;
   logic             run_en;
   logic             irq_en;
   logic             ack;
   logic             running;
   logic             tick;
   logic [CNT_W-1:0] cnt;
   logic [OVF_W-1:0] ovf;
   logic             status;

   pit_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .OVF_W(OVF_W)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .rd_en  (rd_en),
      .addr   (addr),
      .wdata  (wdata),
      .cnt    (cnt),
      .ovf    (ovf),
      .status (status),
      .period (period),
      .run_en (run_en),
      .irq_en (irq_en),
      .ack    (ack),
      .rdata  (rdata)
   );

   pit_prescaler #(.DIV(PRESCALE)) u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (running),
      .tick  (tick)
   );

   pit_interval #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_ival (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (run_en),
      .tick      (tick),
      .ack       (ack),
      .period_in (period),
      .running   (running),
      .cnt_q     (cnt),
      .ovf_q     (ovf),
      .status_q  (status)
   );

   assign irq = status && irq_en;

   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq) else $error("irq without enable"); // R8
   AST_IRQ_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !tick) |=> !irq) else $error("irq survived ack"); // R7
endmodule

// File: tb/pit_timer_tb.sv
`timescale 1ns/1ps
module pit_timer_tb;
   localparam int AW = 5;
   localparam int BIG = 32'h7fff_ffff;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [31:0]   wdata = '0;
   wire  [31:0]   rdata;
   wire           irq;

   pit_timer u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   always #2 clk = ~clk;

   int edges = 0;
   always @(posedge clk) edges <= edges + 1;

   int n_chk = 0;
   int n_bad = 0;

   typedef struct {
      logic [31:0] exp;
      string       tag;
   } item_t;
   item_t sb_q[$];

   // reference state built from the requirements
   int          t_org;
   int          e_stop;
   int          w_base;
   int          w_ack;
   int          per;
   bit          ien_m;
   logic [31:0] mode_m;

   task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%08h expected=%08h", tag, got, exp);
      end
   endtask

   function automatic int m_ticks(input int e);
      int ee;
      ee = (e > e_stop) ? e_stop : e;
      return (ee < t_org) ? 0 : (ee - t_org) / 16;
   endfunction
   function automatic int m_wraps(input int e);
      return w_base + m_ticks(e) / (per + 1);
   endfunction
   function automatic logic [31:0] m_count_word(input int e);
      logic [31:0] v;
      v        = '0;
      v[31:20] = 12'((m_wraps(e) - w_ack) % 4096);
      v[19:0]  = 20'(m_ticks(e) % (per + 1));
      return v;
   endfunction

   // monitor: pops one expected item for every read edge
   logic rd_d = 1'b0;
   always @(posedge clk) rd_d <= rd_en;
   always @(negedge clk) begin
      if (rd_d) begin
         if (sb_q.size() == 0) begin
            check(rdata, 32'hxxxx_xxxx, "scoreboard empty");
         end else begin
            item_t it;
            it = sb_q.pop_front();
            check(rdata, it.exp, it.tag);
         end
      end
   end

   task automatic bus_op(input bit is_wr, input logic [AW-1:0] a, input logic [31:0] d,
                         input int target, output int e_at);
      @(negedge clk);
      rd_en = 1'b0;
      wr_en = 1'b0;
      while (edges + 1 < target) @(negedge clk);
      addr  = a;
      wdata = d;
      if (is_wr) wr_en = 1'b1; else rd_en = 1'b1;
      @(posedge clk);
      #1;
      e_at = edges;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input int target, output int e_at);
      bus_op(1'b1, a, d, target, e_at);
      if (a == 5'h00) begin
         mode_m = 32'h0;
         mode_m[19:0] = d[19:0];
         mode_m[24] = d[24];
         mode_m[25] = d[25];
         ien_m = d[25];
      end
   endtask

   task automatic rd_x(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
      int er;
      item_t it;
      bus_op(1'b0, a, 32'h0, 0, er);
      it.exp = exp;
      it.tag = tag;
      sb_q.push_back(it);
   endtask

   task automatic rd_m(input logic [AW-1:0] a, input int target, input string tag);
      int er;
      int e;
      item_t it;
      bus_op(1'b0, a, 32'h0, target, er);
      e = er - 1;
      case (a)
         5'h00:        it.exp = mode_m;
         5'h04:        it.exp = {31'h0, (m_wraps(e) > w_ack)};
         5'h08, 5'h0C: it.exp = m_count_word(e);
         default:      it.exp = 32'h0;
      endcase
      it.tag = tag;
      sb_q.push_back(it);
      if (a == 5'h08) w_ack = m_wraps(e);
   endtask

   task automatic chk_irq(input string tag);
      @(negedge clk);
      rd_en = 1'b0;
      wr_en = 1'b0;
      check({31'h0, irq}, {31'h0, (ien_m && (m_wraps(edges) > w_ack))}, tag);
   endtask

   task automatic model_idle();
      t_org  = edges;
      e_stop = edges;
      w_base = 0;
      w_ack  = 0;
      per    = 0;
      ien_m  = 1'b0;
      mode_m = 32'h0;
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog (all requirements) actual=%0d expected<%0d cycles", 150000, 150000);
      summary();
      $finish;
   end

   initial begin
      int te;
      int t2;
      model_idle();
      repeat (4) @(posedge clk);
      @(negedge clk);
      check({31'h0, irq}, 32'h0, "R1 irq low in reset");
      rst_n = 1'b1;
      model_idle();

      // R1 reset state of every register, counter halted
      rd_m(5'h00, 0, "R1 mode after reset");
      rd_m(5'h04, 0, "R1 status after reset");
      rd_m(5'h0C, 0, "R1 image after reset");
      rd_m(5'h0C, edges + 40, "R1 counter halted");

      // R2 map, reserved bits, ignored writes, undefined offsets
      wr(5'h00, 32'h0200_0003, 0, te);
      rd_m(5'h00, 0, "R2 mode readback");
      wr(5'h00, 32'hFCF0_0005, 0, te);
      rd_x(5'h00, 32'h0000_0005, "R2 reserved mode bits read zero");
      wr(5'h0C, 32'h0300_0007, 0, te);
      wr(5'h08, 32'h0300_0007, 0, te);
      wr(5'h10, 32'h0300_0007, 0, te);
      rd_x(5'h00, 32'h0000_0005, "R2 write to other offsets ignored");
      rd_m(5'h0C, edges + 40, "R2 no start from ignored write");
      rd_m(5'h10, 0, "R2 undefined offset 0x10 reads zero");
      rd_m(5'h1C, 0, "R2 undefined offset 0x1C reads zero");

      // start: P=3, enable, interrupt enable
      wr(5'h00, 32'h0300_0003, 0, te);
      t_org = te; e_stop = BIG; w_base = 0; w_ack = 0; per = 3;
      rd_m(5'h0C, t_org + 16, "R3 no advance before 16 cycles");
      rd_m(5'h0C, t_org + 17, "R3 first advance at edge 16");
      rd_m(5'h0C, t_org + 16*3 + 1, "R4 count reaches P");
      rd_m(5'h0C, t_org + 16*4 + 1, "R4 wrap after P+1 ticks");
      rd_m(5'h04, 0, "R8 status set by period end");
      chk_irq("R8 irq with status and enable");
      rd_m(5'h0C, t_org + 16*9 + 1, "R5 image fields");
      rd_m(5'h08, t_org + 16*9 + 2, "R5 value view fields");
      rd_m(5'h04, 0, "R7 ack clears status");
      chk_irq("R7 irq drops after ack");
      rd_m(5'h0C, 0, "R7 ack clears period count");
      // acknowledge on the same edge as a period end
      rd_m(5'h08, t_org + 16*12, "R7 ack on wrap edge returns old");
      rd_m(5'h0C, 0, "R7 wrap on ack edge kept");
      rd_m(5'h0C, 0, "R7 image read repeat unchanged");
      rd_m(5'h04, 0, "R7 image reads keep status");

      // R10 new period written mid-period
      wr(5'h00, 32'h0300_0001, t_org + 16*14 + 8, te);
      rd_m(5'h00, 0, "R10 mode shows new period");
      rd_m(5'h0C, t_org + 16*15 + 5, "R10 old period still in force");
      t_org  = t_org + 16*16;
      w_base = 4;
      per    = 1;
      rd_m(5'h0C, t_org + 16*1 + 4, "R10 new period after wrap");
      rd_m(5'h0C, t_org + 16*2 + 4, "R10 new period wraps at P=1");

      // R9 disable mid-period: finish, count it, stop
      wr(5'h00, 32'h0200_0001, t_org + 16*3 + 8, te);
      e_stop = t_org + 16*4;
      rd_m(5'h0C, t_org + 16*4, "R9 still counting after disable");
      rd_m(5'h0C, t_org + 16*4 + 40, "R9 stopped at zero, period counted");
      rd_m(5'h0C, t_org + 16*4 + 200, "R9 remains stopped");
      rd_m(5'h04, 0, "R9 finishing period sets status");
      chk_irq("R8 irq held while stopped");

      // R9 restart: prescaler from zero
      wr(5'h00, 32'h0300_0002, 0, t2);
      w_base = m_wraps(t2);
      t_org  = t2;
      per    = 2;
      e_stop = BIG;
      rd_m(5'h0C, t2 + 16, "R9 restart no early advance");
      rd_m(5'h0C, t2 + 17, "R9 restart first advance");

      // R1 reset while running
      @(negedge clk);
      rd_en = 1'b0;
      wr_en = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check({31'h0, irq}, 32'h0, "R1 irq low in mid-run reset");
      rst_n = 1'b1;
      model_idle();
      rd_m(5'h00, 0, "R1 mode cleared by reset");
      rd_m(5'h0C, edges + 40, "R1 counter halted after reset");

      // R6 wrap modulo 4096 with interrupt disabled
      wr(5'h00, 32'h0100_0000, 0, te);
      t_org = te; e_stop = BIG; w_base = 0; w_ack = 0; per = 0;
      rd_m(5'h0C, t_org + 16*4100 + 8, "R6 period count wraps mod 4096");
      rd_m(5'h04, 0, "R6 status set with interrupt disabled");
      chk_irq("R8 irq low with interrupt disabled");
      wr(5'h00, 32'h0300_0000, 0, te);
      chk_irq("R8 irq rises on interrupt enable");

      @(negedge clk);
      rd_en = 1'b0;
      wr_en = 1'b0;
      repeat (3) @(negedge clk);
      if (sb_q.size() != 0) begin
         n_chk++;
         n_bad++;
         $display("FAIL R2 reads answered actual=%0d pending expected=0", sb_q.size());
      end
      summary();
      $finish;
   end
endmodule